// File: doc/BRIEF.md
# Bridge Cycle Claim and Retry Controller

This block sits between the two ports of a bus bridge, called here the primary (`p_`) and secondary (`s_`) sides. It watches each port for the start of a transaction, which is the active-low frame line going low. It then decodes the address against the window that belongs to the opposite side. If the cycle belongs on the other side, the block claims it with a one-cycle device-select pulse and a termination code. If the target is local to the initiating port, or the address belongs to neither side, the block stays silent.

A claimed memory write is posted: it completes at once and is queued for forwarding. Every other claimed cycle is answered with a retry and kept as a delayed transaction. The block replays each queued cycle as a bus master on the far port. When the initiator repeats the identical request after the far side has finished, the block ends that repeat with the stored completion status. If no device select arrives within the abort window, the far-side master runs the abort sequence: frame is released first and the ready line one clock later. Each direction holds a single entry.

Top module: `bcr_claim_ctrl`

## Requirements
- R1: A cycle started on the primary port is claimed only when its address lies inside the secondary window [SEC_BASE, SEC_LIMIT] (limits inclusive). Addresses in the primary window or in neither window get no device select, no termination code, and no forwarded cycle.
- R2: A cycle started on the secondary port is claimed only when its address lies inside the primary window [PRI_BASE, PRI_LIMIT] and outside the secondary window. Otherwise it gets no response.
- R3: A cycle is not claimed if another agent's device select on the same port (`*_devsel_in_n`) is already low in the clock that starts it.
- R4: A claimed memory write (command 4'b0111) that finds its direction's entry free receives termination code 2'b01 (normal). It is then forwarded on the far port with the same address, command and byte enables.
- R5: Any other claimed command that finds the entry free receives code 2'b10 (retry), is stored, and is forwarded on the far port.
- R6: While a direction's entry is occupied and not yet complete, every claimed cycle in that direction receives retry. This includes posted writes and exact repeats. Such cycles are not stored.
- R7: After the forwarded cycle completes, a repeat whose address, command and byte enables all equal the stored ones ends with the stored status and frees the entry. A repeat that differs in any of them receives retry.
- R8: If the forwarded cycle ended in master abort, the matching repeat receives code 2'b11 (abort status) together with device select.
- R9: The forwarding master drives frame low for one address clock, then drives ready (`*_m_irdy_n`) low. On device select it raises frame while ready stays low for one clock, then raises ready.
- R10: If device select is still high ABORT_CLKS (default 5) clocks after the address clock, the master raises frame and then raises ready one clock later. A device select in the last of those clocks still completes normally.
- R11: Device select and the termination code appear together, on the clock edge that first samples frame low. They last exactly one clock. After reset all outputs are idle: device selects and master lines high, and code 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_frame_n | input | 1 | Primary frame, active low |
| p_addr | input | AW | Primary address |
| p_cmd | input | 4 | Primary command |
| p_be | input | 4 | Primary byte enables |
| p_devsel_in_n | input | 1 | Device select seen on the primary port, active low |
| p_devsel_n | output | 1 | Block's claim on the primary port, active low |
| p_term | output | 2 | Termination code on the primary port |
| p_m_frame_n | output | 1 | Master frame driven on the primary port |
| p_m_irdy_n | output | 1 | Master ready driven on the primary port |
| p_m_addr | output | AW | Forwarded address on the primary port |
| p_m_cmd | output | 4 | Forwarded command on the primary port |
| p_m_be | output | 4 | Forwarded byte enables on the primary port |
| s_frame_n | input | 1 | Secondary frame, active low |
| s_addr | input | AW | Secondary address |
| s_cmd | input | 4 | Secondary command |
| s_be | input | 4 | Secondary byte enables |
| s_devsel_in_n | input | 1 | Device select seen on the secondary port, active low |
| s_devsel_n | output | 1 | Block's claim on the secondary port, active low |
| s_term | output | 2 | Termination code on the secondary port |
| s_m_frame_n | output | 1 | Master frame driven on the secondary port |
| s_m_irdy_n | output | 1 | Master ready driven on the secondary port |
| s_m_addr | output | AW | Forwarded address on the secondary port |
| s_m_cmd | output | 4 | Forwarded command on the secondary port |
| s_m_be | output | 4 | Forwarded byte enables on the secondary port |

## Verification
The claim pulse and its termination code are registered on the edge that first samples frame low. The bench drives frame at a falling clock edge and samples the response at the next falling edge. A stored cycle enters its address clock on the following edge, so the bench finds it already visible when its request task returns. From there it walks the far-port master one falling edge per clock: ready falls one clock after the address clock, the claim or abort edge follows, and ready rises one clock after frame. Completion status becomes usable one edge after the master's last clock. Delayed-transaction tests therefore wait a fixed margin before issuing the repeat.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    typedef enum logic [1:0] {
        TERM_NONE   = 2'b00,
        TERM_NORMAL = 2'b01,
        TERM_RETRY  = 2'b10,
        TERM_ABORT  = 2'b11
    } term_e;

    typedef enum logic [2:0] {
        M_IDLE,
        M_ADDR,
        M_WAIT,
        M_DATA,
        M_ABORT
    } mst_e;

    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

endpackage

// File: rtl/bcr_window_decode.sv
module bcr_window_decode #(
    parameter int              AW        = 32,
    parameter logic [AW-1:0]   PRI_BASE  = 'h0000_0000,
    parameter logic [AW-1:0]   PRI_LIMIT = 'h3FFF_FFFF,
    parameter logic [AW-1:0]   SEC_BASE  = 'h8000_0000,
    parameter logic [AW-1:0]   SEC_LIMIT = 'h8FFF_FFFF
) (
    input  logic [AW-1:0] p_addr,
    input  logic [AW-1:0] s_addr,
    output logic [1:0]    hit
);

    logic p_in_sec;
    logic s_in_sec;
    logic s_in_pri;

    always_comb begin
        p_in_sec = (p_addr >= SEC_BASE) && (p_addr <= SEC_LIMIT);
        s_in_sec = (s_addr >= SEC_BASE) && (s_addr <= SEC_LIMIT);
        s_in_pri = (s_addr >= PRI_BASE) && (s_addr <= PRI_LIMIT);
        // lane 0: primary initiator, target must be behind the secondary port
        hit[0]   = p_in_sec;
        // lane 1: secondary initiator, target must be on the primary side
        hit[1]   = s_in_pri && !s_in_sec;
    end

endmodule

// File: rtl/bcr_claim_slot.sv
module bcr_claim_slot
    import bcr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_n,
    input  logic [AW-1:0] addr,
    input  logic [3:0]    cmd,
    input  logic [3:0]    be,
    input  logic          devsel_in_n,
    input  logic          hit,
    input  logic          fwd_take,
    input  logic          fwd_done,
    input  logic          fwd_abort,
    output logic          devsel_n,
    output logic [1:0]    term,
    output logic          fwd_req,
    output logic [AW-1:0] ent_addr,
    output logic [3:0]    ent_cmd,
    output logic [3:0]    ent_be
);

    typedef struct packed {
        logic          prev_frame;
        logic          devsel_n;
        term_e         term;
        logic          valid;
        logic          post;
        logic          issued;
        logic          done;
        logic          abort;
        logic [AW-1:0] addr;
        logic [3:0]    cmd;
        logic [3:0]    be;
    } slot_t;

    slot_t s_d, s_q;
    logic  start;
    logic  same_req;

    always_comb begin
        s_d            = s_q;
        s_d.prev_frame = frame_n;
        s_d.devsel_n   = 1'b1;
        s_d.term       = TERM_NONE;

        start    = s_q.prev_frame && !frame_n;
        same_req = (addr == s_q.addr) && (cmd == s_q.cmd) && (be == s_q.be);

        if (fwd_take) begin
            s_d.issued = 1'b1;
        end
        if (fwd_done) begin
            s_d.done  = 1'b1;
            s_d.abort = fwd_abort;
            if (s_q.post) begin
                s_d.valid = 1'b0;
            end
        end

        if (start && hit && devsel_in_n) begin
            s_d.devsel_n = 1'b0;
            if (!s_q.valid) begin
                s_d.valid  = 1'b1;
                s_d.post   = (cmd == CMD_MEM_WRITE);
                s_d.issued = 1'b0;
                s_d.done   = 1'b0;
                s_d.abort  = 1'b0;
                s_d.addr   = addr;
                s_d.cmd    = cmd;
                s_d.be     = be;
                s_d.term   = (cmd == CMD_MEM_WRITE) ? TERM_NORMAL : TERM_RETRY;
            end else if (s_q.done && !s_q.post && same_req) begin
                s_d.term  = s_q.abort ? TERM_ABORT : TERM_NORMAL;
                s_d.valid = 1'b0;
            end else begin
                s_d.term = TERM_RETRY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.prev_frame <= 1'b1;
            s_q.devsel_n   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign devsel_n = s_q.devsel_n;
    assign term     = s_q.term;
    assign fwd_req  = s_q.valid && !s_q.issued;
    assign ent_addr = s_q.addr;
    assign ent_cmd  = s_q.cmd;
    assign ent_be   = s_q.be;

endmodule

// File: rtl/bcr_fwd_master.sv
module bcr_fwd_master
    import bcr_pkg::*;
#(
    parameter int AW         = 32,
    parameter int ABORT_CLKS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwd_req,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_cmd,
    input  logic [3:0]    req_be,
    input  logic          devsel_in_n,
    output logic          fwd_take,
    output logic          fwd_done,
    output logic          fwd_abort,
    output logic          m_frame_n,
    output logic          m_irdy_n,
    output logic [AW-1:0] m_addr,
    output logic [3:0]    m_cmd,
    output logic [3:0]    m_be
);

    localparam int            CW        = $clog2(ABORT_CLKS + 1);
    localparam logic [CW-1:0] ABORT_CNT = CW'(ABORT_CLKS);

    typedef struct packed {
        mst_e          state;
        logic          frame_n;
        logic          irdy_n;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [3:0]    cmd;
        logic [3:0]    be;
    } mst_t;

    mst_t m_d, m_q;

    always_comb begin
        m_d      = m_q;
        fwd_take = (m_q.state == M_IDLE) && fwd_req;

        case (m_q.state)
            M_IDLE: begin
                if (fwd_take) begin
                    m_d.state   = M_ADDR;
                    m_d.frame_n = 1'b0;
                    m_d.addr    = req_addr;
                    m_d.cmd     = req_cmd;
                    m_d.be      = req_be;
                end
            end
            M_ADDR: begin
                m_d.state  = M_WAIT;
                m_d.irdy_n = 1'b0;
                m_d.cnt    = CW'(1);
            end
            M_WAIT: begin
                if (!devsel_in_n) begin
                    m_d.frame_n = 1'b1;
                    m_d.state   = M_DATA;
                end else if (m_q.cnt == ABORT_CNT) begin
                    m_d.frame_n = 1'b1;
                    m_d.state   = M_ABORT;
                end else begin
                    m_d.cnt = m_q.cnt + 1'b1;
                end
            end
            M_DATA: begin
                m_d.irdy_n = 1'b1;
                m_d.state  = M_IDLE;
            end
            M_ABORT: begin
                m_d.irdy_n = 1'b1;
                m_d.state  = M_IDLE;
            end
            default: begin
                m_d.state   = M_IDLE;
                m_d.frame_n = 1'b1;
                m_d.irdy_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q         <= '0;
            m_q.state   <= M_IDLE;
            m_q.frame_n <= 1'b1;
            m_q.irdy_n  <= 1'b1;
        end else begin
            m_q <= m_d;
        end
    end

    assign fwd_done  = (m_q.state == M_DATA) || (m_q.state == M_ABORT);
    assign fwd_abort = (m_q.state == M_ABORT);
    assign m_frame_n = m_q.frame_n;
    assign m_irdy_n  = m_q.irdy_n;
    assign m_addr    = m_q.addr;
    assign m_cmd     = m_q.cmd;
    assign m_be      = m_q.be;

endmodule

// File: rtl/bcr_claim_ctrl.sv
module bcr_claim_ctrl #(
    parameter int              AW         = 32,
    parameter int              ABORT_CLKS = 5,
    parameter logic [AW-1:0]   PRI_BASE   = 'h0000_0000,
    parameter logic [AW-1:0]   PRI_LIMIT  = 'h3FFF_FFFF,
    parameter logic [AW-1:0]   SEC_BASE   = 'h8000_0000,
    parameter logic [AW-1:0]   SEC_LIMIT  = 'h8FFF_FFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p_frame_n,
    input  logic [AW-1:0] p_addr,
    input  logic [3:0]    p_cmd,
    input  logic [3:0]    p_be,
    input  logic          p_devsel_in_n,
    output logic          p_devsel_n,
    output logic [1:0]    p_term,
    output logic          p_m_frame_n,
    output logic          p_m_irdy_n,
    output logic [AW-1:0] p_m_addr,
    output logic [3:0]    p_m_cmd,
    output logic [3:0]    p_m_be,
    input  logic          s_frame_n,
    input  logic [AW-1:0] s_addr,
    input  logic [3:0]    s_cmd,
    input  logic [3:0]    s_be,
    input  logic          s_devsel_in_n,
    output logic          s_devsel_n,
    output logic [1:0]    s_term,
    output logic          s_m_frame_n,
    output logic          s_m_irdy_n,
    output logic [AW-1:0] s_m_addr,
    output logic [3:0]    s_m_cmd,
    output logic [3:0]    s_m_be
);

    localparam int LANES = 2;

    // index g: lane whose initiator sits on port g (0 = primary, 1 = secondary);
    // the lane's master drives the opposite port
    logic [LANES-1:0] frame_n_w, devsel_in_w, devsel_w, hit_w;
    logic [LANES-1:0] req_w, take_w, done_w, abort_w, mfr_w, mir_w;
    logic [AW-1:0]    addr_w [LANES];
    logic [AW-1:0]    eaddr_w[LANES];
    logic [AW-1:0]    maddr_w[LANES];
    logic [3:0]       cmd_w  [LANES];
    logic [3:0]       be_w   [LANES];
    logic [3:0]       ecmd_w [LANES];
    logic [3:0]       ebe_w  [LANES];
    logic [3:0]       mcmd_w [LANES];
    logic [3:0]       mbe_w  [LANES];
    logic [1:0]       term_w [LANES];

    assign frame_n_w   = {s_frame_n, p_frame_n};
    assign devsel_in_w = {s_devsel_in_n, p_devsel_in_n};
    assign addr_w[0]   = p_addr;
    assign addr_w[1]   = s_addr;
    assign cmd_w[0]    = p_cmd;
    assign cmd_w[1]    = s_cmd;
    assign be_w[0]     = p_be;
    assign be_w[1]     = s_be;

    bcr_window_decode #(
        .AW(AW), .PRI_BASE(PRI_BASE), .PRI_LIMIT(PRI_LIMIT),
        .SEC_BASE(SEC_BASE), .SEC_LIMIT(SEC_LIMIT)
    ) u_decode (
        .p_addr (p_addr),
        .s_addr (s_addr),
        .hit    (hit_w)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int FAR = LANES - 1 - g;

        bcr_claim_slot #(.AW(AW)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_n     (frame_n_w[g]),
            .addr        (addr_w[g]),
            .cmd         (cmd_w[g]),
            .be          (be_w[g]),
            .devsel_in_n (devsel_in_w[g]),
            .hit         (hit_w[g]),
            .fwd_take    (take_w[g]),
            .fwd_done    (done_w[g]),
            .fwd_abort   (abort_w[g]),
            .devsel_n    (devsel_w[g]),
            .term        (term_w[g]),
            .fwd_req     (req_w[g]),
            .ent_addr    (eaddr_w[g]),
            .ent_cmd     (ecmd_w[g]),
            .ent_be      (ebe_w[g])
        );

        bcr_fwd_master #(.AW(AW), .ABORT_CLKS(ABORT_CLKS)) u_mst (
            .clk         (clk),
            .rst_n       (rst_n),
            .fwd_req     (req_w[g]),
            .req_addr    (eaddr_w[g]),
            .req_cmd     (ecmd_w[g]),
            .req_be      (ebe_w[g]),
            .devsel_in_n (devsel_in_w[FAR]),
            .fwd_take    (take_w[g]),
            .fwd_done    (done_w[g]),
            .fwd_abort   (abort_w[g]),
            .m_frame_n   (mfr_w[g]),
            .m_irdy_n    (mir_w[g]),
            .m_addr      (maddr_w[g]),
            .m_cmd       (mcmd_w[g]),
            .m_be        (mbe_w[g])
        );
    end

    assign p_devsel_n  = devsel_w[0];
    assign p_term      = term_w[0];
    assign s_devsel_n  = devsel_w[1];
    assign s_term      = term_w[1];

    assign s_m_frame_n = mfr_w[0];
    assign s_m_irdy_n  = mir_w[0];
    assign s_m_addr    = maddr_w[0];
    assign s_m_cmd     = mcmd_w[0];
    assign s_m_be      = mbe_w[0];
    assign p_m_frame_n = mfr_w[1];
    assign p_m_irdy_n  = mir_w[1];
    assign p_m_addr    = maddr_w[1];
    assign p_m_cmd     = mcmd_w[1];
    assign p_m_be      = mbe_w[1];

endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
    parameter int            AW         = 32,
    parameter int            ABORT_CLKS = 5,
    parameter logic [AW-1:0] PRI_BASE   = 'h0000_0000,
    parameter logic [AW-1:0] PRI_LIMIT  = 'h3FFF_FFFF,
    parameter logic [AW-1:0] SEC_BASE   = 'h8000_0000,
    parameter logic [AW-1:0] SEC_LIMIT  = 'h8FFF_FFFF
) (
    input logic          clk,
    input logic          rst_n,
    input logic          p_frame_n,
    input logic [AW-1:0] p_addr,
    input logic          p_devsel_in_n,
    input logic          p_devsel_n,
    input logic [1:0]    p_term,
    input logic          p_m_frame_n,
    input logic          p_m_irdy_n,
    input logic          s_frame_n,
    input logic [AW-1:0] s_addr,
    input logic          s_devsel_in_n,
    input logic          s_devsel_n,
    input logic [1:0]    s_term,
    input logic          s_m_frame_n,
    input logic          s_m_irdy_n
);

    logic p_sec_ok, s_pri_ok;
    int   p_low_q, s_low_q;

    assign p_sec_ok = (p_addr >= SEC_BASE) && (p_addr <= SEC_LIMIT);
    assign s_pri_ok = (s_addr >= PRI_BASE) && (s_addr <= PRI_LIMIT)
                   && !((s_addr >= SEC_BASE) && (s_addr <= SEC_LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_low_q <= 0;
            s_low_q <= 0;
        end else begin
            p_low_q <= p_m_frame_n ? 0 : p_low_q + 1;
            s_low_q <= s_m_frame_n ? 0 : s_low_q + 1;
        end
    end

    p_claim_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !p_devsel_n |-> $past(p_sec_ok));
    p_claim_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s_devsel_n |-> $past(s_pri_ok));
    p_other_agent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !p_devsel_n |-> $past(p_devsel_in_n));
    p_other_agent_s_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !s_devsel_n |-> $past(s_devsel_in_n));
    p_claim_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (p_term != 2'b00) == !p_devsel_n);
    p_claim_code_s_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_term != 2'b00) == !s_devsel_n);
    p_claim_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !p_devsel_n |-> (!$past(p_frame_n) && p_devsel_n == 1'b0) ##1 p_devsel_n);
    p_claim_start_s_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !s_devsel_n |-> !$past(s_frame_n) ##1 s_devsel_n);
    p_frame_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_m_irdy_n) |-> $past(s_m_frame_n));
    p_frame_first_p_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_m_irdy_n) |-> $past(p_m_frame_n));
    p_irdy_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_m_irdy_n) |-> !s_m_frame_n);
    p_abort_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_low_q <= ABORT_CLKS + 1);
    p_abort_window_p_r10: assert property (@(posedge clk) disable iff (!rst_n)
        p_low_q <= ABORT_CLKS + 1);

endmodule

bind bcr_claim_ctrl bcr_checker #(
    .AW(AW), .ABORT_CLKS(ABORT_CLKS), .PRI_BASE(PRI_BASE), .PRI_LIMIT(PRI_LIMIT),
    .SEC_BASE(SEC_BASE), .SEC_LIMIT(SEC_LIMIT)
) u_bcr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .p_frame_n     (p_frame_n),
    .p_addr        (p_addr),
    .p_devsel_in_n (p_devsel_in_n),
    .p_devsel_n    (p_devsel_n),
    .p_term        (p_term),
    .p_m_frame_n   (p_m_frame_n),
    .p_m_irdy_n    (p_m_irdy_n),
    .s_frame_n     (s_frame_n),
    .s_addr        (s_addr),
    .s_devsel_in_n (s_devsel_in_n),
    .s_devsel_n    (s_devsel_n),
    .s_term        (s_term),
    .s_m_frame_n   (s_m_frame_n),
    .s_m_irdy_n    (s_m_irdy_n)
);

// File: tb/test_bcr_claim_ctrl.sv
`timescale 1ns/1ps
module test_bcr_claim_ctrl;

    localparam logic [3:0] MW = 4'b0111;
    localparam logic [3:0] MR = 4'b0110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        p_frame_n = 1'b1, s_frame_n = 1'b1;
    logic [31:0] p_addr = '0, s_addr = '0;
    logic [3:0]  p_cmd = '0, s_cmd = '0, p_be = '0, s_be = '0;
    logic        p_devsel_in_n, s_devsel_in_n;
    logic        p_devsel_n, s_devsel_n;
    logic [1:0]  p_term, s_term;
    logic        p_m_frame_n, p_m_irdy_n, s_m_frame_n, s_m_irdy_n;
    logic [31:0] p_m_addr, s_m_addr;
    logic [3:0]  p_m_cmd, s_m_cmd, p_m_be, s_m_be;

    logic p_resp_n = 1'b1, s_resp_n = 1'b1, p_force_n = 1'b1, s_force_n = 1'b1;
    int   p_dly = 1, s_dly = 1, p_lowc = 0, s_lowc = 0;
    int   checks = 0, errors = 0;
    bit   finished = 1'b0;

    assign p_devsel_in_n = p_resp_n & p_force_n;
    assign s_devsel_in_n = s_resp_n & s_force_n;

    always #4 clk = ~clk;

    bcr_claim_ctrl i_bcr_claim_ctrl (
        .clk(clk), .rst_n(rst_n),
        .p_frame_n(p_frame_n), .p_addr(p_addr), .p_cmd(p_cmd), .p_be(p_be),
        .p_devsel_in_n(p_devsel_in_n), .p_devsel_n(p_devsel_n), .p_term(p_term),
        .p_m_frame_n(p_m_frame_n), .p_m_irdy_n(p_m_irdy_n), .p_m_addr(p_m_addr),
        .p_m_cmd(p_m_cmd), .p_m_be(p_m_be),
        .s_frame_n(s_frame_n), .s_addr(s_addr), .s_cmd(s_cmd), .s_be(s_be),
        .s_devsel_in_n(s_devsel_in_n), .s_devsel_n(s_devsel_n), .s_term(s_term),
        .s_m_frame_n(s_m_frame_n), .s_m_irdy_n(s_m_irdy_n), .s_m_addr(s_m_addr),
        .s_m_cmd(s_m_cmd), .s_m_be(s_m_be)
    );

    // far-side target models: claim in the WAIT clock numbered *_dly (-1: never)
    always @(negedge clk) begin
        s_lowc = (s_m_frame_n === 1'b0) ? s_lowc + 1 : 0;
        if (s_lowc == 0) s_resp_n = 1'b1;
        else if (s_dly >= 1 && s_lowc == s_dly + 1) s_resp_n = 1'b0;
        p_lowc = (p_m_frame_n === 1'b0) ? p_lowc + 1 : 0;
        if (p_lowc == 0) p_resp_n = 1'b1;
        else if (p_dly >= 1 && p_lowc == p_dly + 1) p_resp_n = 1'b0;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input bit on_s, input logic [31:0] a, input logic [3:0] c,
                         input logic [3:0] b, output logic dsel, output logic [1:0] t);
        if (on_s) begin s_frame_n = 1'b0; s_addr = a; s_cmd = c; s_be = b; end
        else      begin p_frame_n = 1'b0; p_addr = a; p_cmd = c; p_be = b; end
        @(negedge clk);
        dsel = on_s ? s_devsel_n : p_devsel_n;
        t    = on_s ? s_term : p_term;
        p_frame_n = 1'b1;
        s_frame_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_m_start(input bit on_s);
        for (int i = 0; i < 20; i++) begin
            if ((on_s ? s_m_frame_n : p_m_frame_n) == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R11 reset p_devsel_n", p_devsel_n, 1);
        chk("R11 reset s_devsel_n", s_devsel_n, 1);
        chk("R11 reset p_term", p_term, 0);
        chk("R11 reset s_term", s_term, 0);
        chk("R11 reset masters", {p_m_frame_n, p_m_irdy_n, s_m_frame_n, s_m_irdy_n}, 4'hF);
    endtask

    task automatic t_no_claim_primary;
        logic d; logic [1:0] t;
        issue(0, 32'h1000_0000, MR, 4'hF, d, t);
        chk("R1 local target devsel", d, 1);
        chk("R1 local target term", t, 0);
        issue(0, 32'h5000_0000, MR, 4'hF, d, t);
        chk("R1 unmapped devsel", d, 1);
        chk("R1 unmapped term", t, 0);
        issue(0, 32'h9000_0000, MW, 4'hF, d, t);
        chk("R1 above limit devsel", d, 1);
        repeat (3) @(negedge clk);
        chk("R1 nothing forwarded", s_m_frame_n, 1);
    endtask

    task automatic t_no_claim_secondary;
        logic d; logic [1:0] t;
        issue(1, 32'h8000_0000, MR, 4'hF, d, t);
        chk("R2 local target devsel", d, 1);
        chk("R2 local target term", t, 0);
        issue(1, 32'h5000_0000, MR, 4'hF, d, t);
        chk("R2 unmapped devsel", d, 1);
        repeat (3) @(negedge clk);
        chk("R2 nothing forwarded", p_m_frame_n, 1);
    endtask

    task automatic t_other_agent;
        logic d; logic [1:0] t;
        p_force_n = 1'b0;
        issue(0, 32'h8000_0020, MR, 4'hF, d, t);
        p_force_n = 1'b1;
        chk("R3 other agent devsel", d, 1);
        chk("R3 other agent term", t, 0);
        repeat (3) @(negedge clk);
        chk("R3 nothing forwarded", s_m_frame_n, 1);
    endtask

    task automatic t_posted;
        logic d; logic [1:0] t;
        s_dly = 1;
        issue(0, 32'h8000_0010, MW, 4'h3, d, t);
        chk("R4 posted devsel", d, 0);
        chk("R4 posted term normal", t, 2'b01);
        chk("R11 devsel one clock", p_devsel_n, 1);
        wait_m_start(1);
        chk("R4 forwarded addr", s_m_addr, 32'h8000_0010);
        chk("R4 forwarded cmd/be", {s_m_cmd, s_m_be}, {MW, 4'h3});
        chk("R9 address clock", {s_m_frame_n, s_m_irdy_n}, 2'b01);
        @(negedge clk);
        chk("R9 ready low", {s_m_frame_n, s_m_irdy_n}, 2'b00);
        @(negedge clk);
        chk("R9 frame released first", {s_m_frame_n, s_m_irdy_n}, 2'b10);
        @(negedge clk);
        chk("R9 both released", {s_m_frame_n, s_m_irdy_n}, 2'b11);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_delayed;
        logic d; logic [1:0] t;
        s_dly = 5;
        issue(0, 32'h8000_0100, MR, 4'hF, d, t);
        chk("R5 read devsel", d, 0);
        chk("R5 read retry", t, 2'b10);
        issue(0, 32'h8000_0100, MR, 4'hF, d, t);
        chk("R6 early repeat retry", t, 2'b10);
        issue(0, 32'h8000_0200, MW, 4'hF, d, t);
        chk("R6 posted while busy retry", t, 2'b10);
        repeat (8) @(negedge clk);
        issue(0, 32'h8000_0100, MR, 4'h1, d, t);
        chk("R7 mismatched be retry", t, 2'b10);
        issue(0, 32'h8000_0104, MR, 4'hF, d, t);
        chk("R7 mismatched addr retry", t, 2'b10);
        issue(0, 32'h8000_0100, MR, 4'hF, d, t);
        chk("R7 matching repeat devsel", d, 0);
        chk("R10 last-slot select is normal", t, 2'b01);
        issue(0, 32'h8000_0300, MW, 4'hF, d, t);
        chk("R7 entry freed, posted accepted", t, 2'b01);
        repeat (6) @(negedge clk);
        s_dly = 1;
    endtask

    task automatic t_abort;
        logic d; logic [1:0] t;
        p_dly = -1;
        issue(1, 32'h2000_0040, MR, 4'hC, d, t);
        chk("R5 secondary read retry", t, 2'b10);
        wait_m_start(0);
        chk("R5 forwarded to primary", {p_m_addr, p_m_cmd, p_m_be}, {32'h2000_0040, MR, 4'hC});
        chk("R10 address clock", {p_m_frame_n, p_m_irdy_n}, 2'b01);
        for (int i = 2; i <= 6; i++) begin
            @(negedge clk);
            chk("R10 waiting for select", {p_m_frame_n, p_m_irdy_n}, 2'b00);
        end
        @(negedge clk);
        chk("R10 abort frame first", {p_m_frame_n, p_m_irdy_n}, 2'b10);
        @(negedge clk);
        chk("R10 abort ready last", {p_m_frame_n, p_m_irdy_n}, 2'b11);
        repeat (2) @(negedge clk);
        issue(1, 32'h2000_0040, MR, 4'hC, d, t);
        chk("R8 abort status devsel", d, 0);
        chk("R8 abort status code", t, 2'b11);
        p_dly = 1;
    endtask

    task automatic t_limit;
        logic d; logic [1:0] t;
        issue(0, 32'h8FFF_FFFF, MW, 4'hF, d, t);
        chk("R1 window limit claimed", {d, t}, {1'b0, 2'b01});
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_claim_primary();
        t_no_claim_secondary();
        t_other_agent();
        t_posted();
        t_delayed();
        t_abort();
        t_limit();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule